// File: doc/BRIEF.md
# USB Host Controller Register Window Stub

This block is a memory-mapped byte register file that stands in for a minimal USB host controller of the open host controller kind. Boot firmware and drivers that probe such a controller find identity bytes at fixed offsets. They also find that a requested controller reset has already completed, and that an ownership request from system-management code has been granted. No list processing, frame timing, root-hub port logic or interrupt generation takes place.

The block claims a 4 KiB window. Its base address is assembled from three configuration bytes, which supply address bits 31:8, and is then forced to a 4 KiB boundary. Reads return the stored byte in the same cycle. Writes store the byte at the next clock edge, with one exception: the command-status byte at offset 0x08 is filtered, and a write to it may also update two other bytes.

Top module: `ohci_reg_stub`

## Requirements
- R1: After reset, byte 0x00 reads 0x10, byte 0x01 reads 0x01, byte 0x48 reads 0x02, and every other byte reads 0x00.
- R2: The window base is {cfg_base_hi, cfg_base_mid, cfg_base_lo, 8'h00} with bits 11:0 forced to zero, so the low nibble of cfg_base_lo has no effect on decoding.
- R3: An access is claimed (acc_claim=1) only when acc_valid=1, cfg_mem_en=1, the base is nonzero, and acc_addr[31:12] equals base bits 31:12.
- R4: A claimed read returns, in the same cycle, the stored byte selected by acc_addr[11:0]. acc_rdata is 0x00 whenever no read is claimed.
- R5: A claimed write to any offset other than 0x08 stores acc_wdata at that offset, and the new value is readable from the next cycle on.
- R6: A claimed write to offset 0x08 stores acc_wdata with bit 0 forced to 0.
- R7: A claimed write to offset 0x08 with any of acc_wdata[3:0] set also sets byte 0x0F to 0x40 and clears bit 0 of byte 0x05 (its other bits kept), in the same clock as the store.
- R8: A claimed write to offset 0x08 with acc_wdata[3:0]=0 leaves bytes 0x05 and 0x0F unchanged.
- R9: A write that is not claimed changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base_lo | input | 8 | Base address bits 15:8 (low nibble masked) |
| cfg_base_mid | input | 8 | Base address bits 23:16 |
| cfg_base_hi | input | 8 | Base address bits 31:24 |
| cfg_mem_en | input | 1 | Memory decode enable |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Byte address |
| acc_wdata | input | 8 | Write byte |
| acc_claim | output | 1 | Access decoded inside the window |
| acc_rdata | output | 8 | Read byte (combinational) |

## Verification
Claim and read data are combinational, so they are due in the same cycle as the request. The bench drives each request on a falling edge and samples one nanosecond later, well before the rising edge. A write, including the filtered command byte and both ownership side effects, lands at the first rising edge after it is presented. The bench therefore reads the affected bytes in the following cycle, never in the same one. The ignored-write cases re-enable the window afterwards and read the target offsets back, so that any stray store would be visible at the ports.

// File: rtl/ohcs_pkg.sv
package ohcs_pkg;

    // Default geometry
    localparam int DEF_ADDR_W   = 32;
    localparam int DEF_WIN_BITS = 12;
    localparam int BYTE_W       = 8;

    // Offsets whose behaviour is special
    localparam int OFF_REV_LO   = 'h000;
    localparam int OFF_REV_HI   = 'h001;
    localparam int OFF_SMI_SRC  = 'h005;
    localparam int OFF_CMDSTS   = 'h008;
    localparam int OFF_OWN_FLAG = 'h00F;
    localparam int OFF_PORTCNT  = 'h048;

    localparam logic [BYTE_W-1:0] OWN_GRANTED = 8'h40;

    // Side-effect flags derived from a write
    typedef struct packed {
        logic is_cmd;   // write targets the command-status byte
        logic handoff;  // ownership change requested
    } cmd_fx_t;

    // Power-on content of one byte of the window
    function automatic logic [BYTE_W-1:0] reset_byte(input int off);
        case (off)
            OFF_REV_LO:  return 8'h10;
            OFF_REV_HI:  return 8'h01;
            OFF_PORTCNT: return 8'h02;
            default:     return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/ohcs_window_dec.sv
module ohcs_window_dec
    import ohcs_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int WIN_BITS = DEF_WIN_BITS
) (
    input  logic [BYTE_W-1:0]   base_lo,
    input  logic [BYTE_W-1:0]   base_mid,
    input  logic [BYTE_W-1:0]   base_hi,
    input  logic                mem_en,
    input  logic [ADDR_W-1:0]   addr,
    output logic                in_win,
    output logic [WIN_BITS-1:0] off
);
    localparam int RAW_W = 4 * BYTE_W;
    localparam logic [ADDR_W-1:0] WIN_MASK = ~((ADDR_W'(1) << WIN_BITS) - ADDR_W'(1));

    logic [RAW_W-1:0]  base_raw;
    logic [ADDR_W-1:0] base_win;

    always_comb begin
        base_raw = {base_hi, base_mid, base_lo, {BYTE_W{1'b0}}};
        base_win = ADDR_W'(base_raw) & WIN_MASK;
        in_win   = mem_en && (|base_win)
                   && (addr[ADDR_W-1:WIN_BITS] == base_win[ADDR_W-1:WIN_BITS]);
        off      = addr[WIN_BITS-1:0];
    end
endmodule

// File: rtl/ohcs_cmd_filter.sv
module ohcs_cmd_filter
    import ohcs_pkg::*;
#(
    parameter int WIN_BITS = DEF_WIN_BITS
) (
    input  logic [WIN_BITS-1:0] off,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   store_data,
    output cmd_fx_t             fx
);
    always_comb begin
        fx.is_cmd  = (off == WIN_BITS'(OFF_CMDSTS));
        fx.handoff = fx.is_cmd && (|wdata[3:0]);
        store_data = wdata;
        if (fx.is_cmd)
            store_data[0] = 1'b0;   // reset request reads back as done
    end
endmodule

// File: rtl/ohcs_regfile.sv
module ohcs_regfile
    import ohcs_pkg::*;
#(
    parameter int WIN_BITS = DEF_WIN_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [WIN_BITS-1:0] wr_off,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                handoff,
    input  logic [WIN_BITS-1:0] rd_off,
    output logic [BYTE_W-1:0]   rd_byte
);
    localparam int DEPTH = 1 << WIN_BITS;

    logic [BYTE_W-1:0] bytes_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                bytes_q[i] <= reset_byte(i);
        end else begin
            if (we)
                bytes_q[wr_off] <= wr_data;
            if (we && handoff) begin
                bytes_q[OFF_OWN_FLAG]   <= OWN_GRANTED;
                bytes_q[OFF_SMI_SRC][0] <= 1'b0;
            end
        end
    end

    assign rd_byte = bytes_q[rd_off];
endmodule

// File: rtl/ohci_reg_stub.sv
module ohci_reg_stub
    import ohcs_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int WIN_BITS = DEF_WIN_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        cfg_base_lo,
    input  logic [7:0]        cfg_base_mid,
    input  logic [7:0]        cfg_base_hi,
    input  logic              cfg_mem_en,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic              acc_claim,
    output logic [7:0]        acc_rdata
);
    logic                in_win;
    logic [WIN_BITS-1:0] off;
    logic [BYTE_W-1:0]   store_data;
    cmd_fx_t             fx;
    logic [BYTE_W-1:0]   rd_byte;
    logic                do_wr;

    ohcs_window_dec #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_dec (
        .base_lo  (cfg_base_lo),
        .base_mid (cfg_base_mid),
        .base_hi  (cfg_base_hi),
        .mem_en   (cfg_mem_en),
        .addr     (acc_addr),
        .in_win   (in_win),
        .off      (off)
    );

    ohcs_cmd_filter #(.WIN_BITS(WIN_BITS)) u_flt (
        .off        (off),
        .wdata      (acc_wdata),
        .store_data (store_data),
        .fx         (fx)
    );

    assign acc_claim = acc_valid && in_win;
    assign do_wr     = acc_claim && acc_write;

    ohcs_regfile #(.WIN_BITS(WIN_BITS)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (do_wr),
        .wr_off  (off),
        .wr_data (store_data),
        .handoff (fx.handoff),
        .rd_off  (off),
        .rd_byte (rd_byte)
    );

    assign acc_rdata = (acc_claim && !acc_write) ? rd_byte : '0;
endmodule

// File: rtl/ohcs_chk.sv
module ohcs_chk #(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_mem_en,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [7:0]        acc_wdata,
    input logic              acc_claim,
    input logic [7:0]        acc_rdata
);
    logic rd_hit;
    logic wr_hit;
    logic [WIN_BITS-1:0] o;
    assign rd_hit = acc_claim && !acc_write;
    assign wr_hit = acc_claim && acc_write;
    assign o      = acc_addr[WIN_BITS-1:0];

    // R1
    rev_lo_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && rd_hit && o == WIN_BITS'(0)) |-> acc_rdata == 8'h10);

    // R3
    claim_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        acc_claim |-> (cfg_mem_en && acc_valid));

    // R4
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |-> acc_rdata == 8'h00);

    // R5
    write_then_read_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_hit) && !$past(rst) && rd_hit && acc_addr == $past(acc_addr)
         && o != WIN_BITS'(5) && o != WIN_BITS'(8) && o != WIN_BITS'(15))
        |-> acc_rdata == $past(acc_wdata));

    // R6
    cmd_bit0_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && o == WIN_BITS'(8)) |-> acc_rdata[0] == 1'b0);

    // R7
    handoff_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_hit && o == WIN_BITS'(8) && (|acc_wdata[3:0])) && !$past(rst)
         && rd_hit && o == WIN_BITS'(15)) |-> acc_rdata == 8'h40);
endmodule

bind ohci_reg_stub ohcs_chk #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_mem_en (cfg_mem_en),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .acc_claim  (acc_claim),
    .acc_rdata  (acc_rdata)
);

// File: tb/sim_ohci_reg_stub.sv
`timescale 1ns/1ps
module sim_ohci_reg_stub;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_base_lo = '0, cfg_base_mid = '0, cfg_base_hi = '0;
    logic        cfg_mem_en = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic        acc_claim;
    logic [7:0]  acc_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam logic [31:0] BASE = 32'hFEDC_B000;

    always #4 clk = ~clk;

    ohci_reg_stub u0 (
        .clk(clk), .rst(rst),
        .cfg_base_lo(cfg_base_lo), .cfg_base_mid(cfg_base_mid), .cfg_base_hi(cfg_base_hi),
        .cfg_mem_en(cfg_mem_en),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_claim(acc_claim), .acc_rdata(acc_rdata)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // One bus cycle: drive on falling edge, sample 1 ns later, commit at rising edge.
    task automatic bus(input logic wr, input logic [31:0] a, input logic [7:0] d,
                       output logic claim, output logic [7:0] rd);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
        #1;
        claim = acc_claim;
        rd    = acc_rdata;
        @(posedge clk);
        #1;
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic wr8(input logic [31:0] a, input logic [7:0] d);
        logic c; logic [7:0] r;
        bus(1'b1, a, d, c, r);
    endtask

    task automatic rd_chk(input string req, input logic [31:0] a, input logic [7:0] exp);
        logic c; logic [7:0] r;
        bus(1'b0, a, 8'h00, c, r);
        check(req, {31'd0, c}, 32'd1);
        check(req, {24'd0, r}, {24'd0, exp});
    endtask

    task automatic set_base(input logic [7:0] hi, input logic [7:0] mid, input logic [7:0] lo,
                            input logic en);
        @(negedge clk);
        cfg_base_hi = hi; cfg_base_mid = mid; cfg_base_lo = lo; cfg_mem_en = en;
    endtask

    task automatic t_reset_values;
        // R1: identity bytes and zeros elsewhere
        rd_chk("R1", BASE + 32'h000, 8'h10);
        rd_chk("R1", BASE + 32'h001, 8'h01);
        rd_chk("R1", BASE + 32'h048, 8'h02);
        rd_chk("R1", BASE + 32'h004, 8'h00);
        rd_chk("R1", BASE + 32'hFFF, 8'h00);
        rd_chk("R1", BASE + 32'h00F, 8'h00);
    endtask

    task automatic t_read_write;
        // R5 / R4: store and read back at low and top offsets
        wr8(BASE + 32'h020, 8'hA5);
        rd_chk("R5", BASE + 32'h020, 8'hA5);
        wr8(BASE + 32'hFFF, 8'h3C);
        rd_chk("R4", BASE + 32'hFFF, 8'h3C);
        wr8(BASE + 32'h000, 8'h77);
        rd_chk("R5", BASE + 32'h000, 8'h77);
    endtask

    task automatic t_base_decode;
        logic c; logic [7:0] r;
        // R2: low nibble of cfg_base_lo (0xBA -> 0xB0) must not move the window
        bus(1'b0, 32'hFEDC_B020, 8'h00, c, r);
        check("R2", {31'd0, c}, 32'd1);
        bus(1'b0, 32'hFEDC_A020, 8'h00, c, r);
        check("R2", {31'd0, c}, 32'd0);
        check("R4", {24'd0, r}, 32'd0);
        bus(1'b0, 32'hFEDC_C000, 8'h00, c, r);
        check("R2", {31'd0, c}, 32'd0);
    endtask

    task automatic t_disabled;
        logic c; logic [7:0] r;
        // R3 / R9: decode disabled, write ignored
        set_base(8'hFE, 8'hDC, 8'hBA, 1'b0);
        bus(1'b1, BASE + 32'h020, 8'h11, c, r);
        check("R3", {31'd0, c}, 32'd0);
        // R3: base zero with enable set claims nothing
        set_base(8'h00, 8'h00, 8'h0F, 1'b1);
        bus(1'b1, 32'h0000_0020, 8'h22, c, r);
        check("R3", {31'd0, c}, 32'd0);
        set_base(8'hFE, 8'hDC, 8'hBA, 1'b1);
        rd_chk("R9", BASE + 32'h020, 8'hA5);
        // R9: write outside the window leaves offset 0x20 untouched
        wr8(32'hFEDC_A020, 8'h33);
        rd_chk("R9", BASE + 32'h020, 8'hA5);
    endtask

    task automatic t_command;
        wr8(BASE + 32'h005, 8'h07);
        wr8(BASE + 32'h00F, 8'h11);
        // R8: low nibble zero, no side effects
        wr8(BASE + 32'h008, 8'hF0);
        rd_chk("R8", BASE + 32'h008, 8'hF0);
        rd_chk("R8", BASE + 32'h005, 8'h07);
        rd_chk("R8", BASE + 32'h00F, 8'h11);
        // R6 / R7: bit 0 cleared, ownership granted
        wr8(BASE + 32'h008, 8'h09);
        rd_chk("R6", BASE + 32'h008, 8'h08);
        rd_chk("R7", BASE + 32'h005, 8'h06);
        rd_chk("R7", BASE + 32'h00F, 8'h40);
        // R6: reset request alone also triggers handoff; stored byte 0x80
        wr8(BASE + 32'h00F, 8'h00);
        wr8(BASE + 32'h008, 8'h81);
        rd_chk("R6", BASE + 32'h008, 8'h80);
        rd_chk("R7", BASE + 32'h00F, 8'h40);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cfg_base_hi = 8'hFE; cfg_base_mid = 8'hDC; cfg_base_lo = 8'hBA; cfg_mem_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_values();
        t_read_write();
        t_base_decode();
        t_disabled();
        t_command();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule